// File: doc/BRIEF.md
# Global Channel Reservation Unit

This block decides how a packet leaves its group. A minimal route crosses one global channel, and that channel keeps a running total of the flits already promised to it. Before a packet is routed, its source asks that channel for room. The channel grants the request if the new flits still fit under a programmable ceiling. Otherwise it refuses. The packet then goes the minimal way on a grant and through a random intermediate group on a refusal.

The unit has two halves that the surrounding network joins. The channel side receives request flits, keeps the reservation total and returns a tagged accept or reject flit one cycle later. It lowers the total by one for every reserved flit that actually departs on the channel. The source side parks injected packets in a small holding buffer and sends one request at a time, carrying the packet length and a tag. It waits for the reply whose tag matches and then emits a routing decision. If no reply arrives within a fixed number of cycles, the source treats the request as refused. The reservation handshake costs the same for every packet, so short packets carry more overhead per flit.

Top module: `gc_reserve_unit`

## Requirements
- R1: A request of length L is granted (reply ok = 1) exactly when the reservation total plus L is at most `thresh`. Otherwise it is refused (ok = 0).
- R2: A granted request adds L to the reservation total seen on `resv_count` in the cycle its reply is valid.
- R3: Each cycle with `flit_sent` high lowers the total by one. At zero the total stays at zero.
- R4: A grant and a `flit_sent` in the same cycle are both applied, giving total + L - 1.
- R5: A refused request leaves the total unchanged, apart from any release in the same cycle.
- R6: Every request flit receives exactly one reply in the following cycle. The reply carries the request's tag.
- R7: Packets leave the holding buffer in arrival order. Each packet produces one request flit carrying its length, and one decision carrying its id and length.
- R8: A reply with a matching tag and ok = 1 yields a decision with `dec_minimal` = 1. With ok = 0 it yields `dec_minimal` = 0.
- R9: A reply whose tag differs from the outstanding request's tag is ignored.
- R10: If no matching reply arrives, the decision is emitted with `dec_minimal` = 0 exactly TIMEOUT cycles after the request flit.
- R11: After reset the total is 0, `req_valid`, `chr_valid` and `dec_valid` are low and `pkt_ready` is high. `pkt_ready` drops once DEPTH packets wait behind the one in flight.
- R12: At most one request is outstanding. `req_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | CNT_W | Reservation ceiling in flits |
| pkt_valid | input | 1 | Packet offered for injection |
| pkt_id | input | ID_W | Packet identifier |
| pkt_len | input | LEN_W | Packet length in flits |
| pkt_ready | output | 1 | Holding buffer has room |
| req_valid | output | 1 | Request flit toward the channel |
| req_tag | output | TAG_W | Request tag |
| req_len | output | LEN_W | Requested flit count |
| rsp_in_valid | input | 1 | Reply flit arriving at the source |
| rsp_in_tag | input | TAG_W | Tag of that reply |
| rsp_in_ok | input | 1 | 1 = granted |
| dec_valid | output | 1 | Routing decision pulse |
| dec_id | output | ID_W | Id of the decided packet |
| dec_len | output | LEN_W | Length of the decided packet |
| dec_minimal | output | 1 | 1 = minimal route, 0 = Valiant route |
| chq_valid | input | 1 | Request flit arriving at the channel |
| chq_tag | input | TAG_W | Its tag |
| chq_len | input | LEN_W | Its flit count |
| chr_valid | output | 1 | Reply flit from the channel |
| chr_tag | output | TAG_W | Tag echoed in the reply |
| chr_ok | output | 1 | Grant result |
| flit_sent | input | 1 | One reserved flit left on the channel |
| resv_count | output | CNT_W | Current reservation total |

## Verification
Some properties are checked on every cycle: the one-cycle reply with the echoed tag, the grant rule against the previous total, the unchanged total on a refusal, the release step and the floor at zero, and the single outstanding request. Other behaviour only shows up in the bench scenarios. These include the grant boundary at exactly the ceiling, the combined grant and release, the timeout falling on an exact cycle, a stale tagged reply being ignored, the buffer filling after DEPTH+1 back-to-back packets, and decisions leaving in arrival order.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  typedef enum logic [0:0] {
    SRC_IDLE = 1'b0,
    SRC_WAIT = 1'b1
  } src_state_t;
endpackage

// File: rtl/gcr_fifo.sv
module gcr_fifo #(
  parameter int DW    = 14,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;
  logic             do_wr, do_rd;

  assign full  = (fill == CNT_W'(DEPTH));
  assign empty = (fill == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // write port: no reset, so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/gcr_chan_counter.sv
module gcr_chan_counter #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 6,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] thresh,
  input  logic             chq_valid,
  input  logic [TAG_W-1:0] chq_tag,
  input  logic [LEN_W-1:0] chq_len,
  input  logic             flit_sent,
  output logic             chr_valid,
  output logic [TAG_W-1:0] chr_tag,
  output logic             chr_ok,
  output logic [CNT_W-1:0] resv_count
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] prospective;
  logic [SUM_W-1:0] grown;
  logic             fits;
  logic [CNT_W-1:0] count_nxt;

  // widened sum so the ceiling compare cannot wrap
  assign prospective = SUM_W'(resv_count) + SUM_W'(chq_len);
  assign fits        = prospective <= SUM_W'(thresh);
  assign grown       = (chq_valid && fits) ? prospective : SUM_W'(resv_count);

  always_comb begin
    if (flit_sent && grown != '0) count_nxt = CNT_W'(grown - 1'b1);
    else                          count_nxt = CNT_W'(grown);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resv_count <= '0;
      chr_valid  <= 1'b0;
      chr_tag    <= '0;
      chr_ok     <= 1'b0;
    end else begin
      resv_count <= count_nxt;
      chr_valid  <= chq_valid;
      if (chq_valid) begin
        chr_tag <= chq_tag;
        chr_ok  <= fits;
      end
    end
  end
endmodule

// File: rtl/gcr_requester.sv
module gcr_requester
  import gcr_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int LEN_W   = 6,
  parameter int TAG_W   = 4,
  parameter int DEPTH   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_valid,
  input  logic [ID_W-1:0]  pkt_id,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             pkt_ready,
  output logic             req_valid,
  output logic [TAG_W-1:0] req_tag,
  output logic [LEN_W-1:0] req_len,
  input  logic             rsp_in_valid,
  input  logic [TAG_W-1:0] rsp_in_tag,
  input  logic             rsp_in_ok,
  output logic             dec_valid,
  output logic [ID_W-1:0]  dec_id,
  output logic [LEN_W-1:0] dec_len,
  output logic             dec_minimal
);
  localparam int DW    = ID_W + LEN_W;
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  src_state_t       state;
  logic [DW-1:0]    head;
  logic             full, empty, pop;
  logic [TMR_W-1:0] timer;
  logic             match, expired;

  gcr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (pkt_valid),
    .wr_data ({pkt_id, pkt_len}),
    .rd_en   (pop),
    .rd_data (head),
    .full    (full),
    .empty   (empty)
  );

  assign pkt_ready = !full;
  assign pop       = (state == SRC_IDLE) && !empty;
  assign req_len   = head[LEN_W-1:0];
  assign match     = (state == SRC_WAIT) && rsp_in_valid && (rsp_in_tag == req_tag);
  assign expired   = (state == SRC_WAIT) && (timer == TMR_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SRC_IDLE;
      req_valid   <= 1'b0;
      req_tag     <= '0;
      timer       <= '0;
      dec_valid   <= 1'b0;
      dec_id      <= '0;
      dec_len     <= '0;
      dec_minimal <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      dec_valid <= 1'b0;
      case (state)
        SRC_IDLE: begin
          if (pop) begin
            state     <= SRC_WAIT;
            req_valid <= 1'b1;
            req_tag   <= req_tag + 1'b1;
            timer     <= '0;
          end
        end
        SRC_WAIT: begin
          if (match || expired) begin
            state       <= SRC_IDLE;
            dec_valid   <= 1'b1;
            dec_id      <= head[DW-1:LEN_W];
            dec_len     <= head[LEN_W-1:0];
            dec_minimal <= match && rsp_in_ok;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= SRC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gc_reserve_unit.sv
module gc_reserve_unit #(
  parameter int ID_W    = 8,
  parameter int LEN_W   = 6,
  parameter int TAG_W   = 4,
  parameter int CNT_W   = 8,
  parameter int DEPTH   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] thresh,
  input  logic             pkt_valid,
  input  logic [ID_W-1:0]  pkt_id,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             pkt_ready,
  output logic             req_valid,
  output logic [TAG_W-1:0] req_tag,
  output logic [LEN_W-1:0] req_len,
  input  logic             rsp_in_valid,
  input  logic [TAG_W-1:0] rsp_in_tag,
  input  logic             rsp_in_ok,
  output logic             dec_valid,
  output logic [ID_W-1:0]  dec_id,
  output logic [LEN_W-1:0] dec_len,
  output logic             dec_minimal,
  input  logic             chq_valid,
  input  logic [TAG_W-1:0] chq_tag,
  input  logic [LEN_W-1:0] chq_len,
  output logic             chr_valid,
  output logic [TAG_W-1:0] chr_tag,
  output logic             chr_ok,
  input  logic             flit_sent,
  output logic [CNT_W-1:0] resv_count
);
  gcr_requester #(
    .ID_W(ID_W), .LEN_W(LEN_W), .TAG_W(TAG_W),
    .DEPTH(DEPTH), .TIMEOUT(TIMEOUT)
  ) u_src (
    .clk          (clk),
    .rst          (rst),
    .pkt_valid    (pkt_valid),
    .pkt_id       (pkt_id),
    .pkt_len      (pkt_len),
    .pkt_ready    (pkt_ready),
    .req_valid    (req_valid),
    .req_tag      (req_tag),
    .req_len      (req_len),
    .rsp_in_valid (rsp_in_valid),
    .rsp_in_tag   (rsp_in_tag),
    .rsp_in_ok    (rsp_in_ok),
    .dec_valid    (dec_valid),
    .dec_id       (dec_id),
    .dec_len      (dec_len),
    .dec_minimal  (dec_minimal)
  );

  gcr_chan_counter #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .TAG_W(TAG_W)
  ) u_chan (
    .clk        (clk),
    .rst        (rst),
    .thresh     (thresh),
    .chq_valid  (chq_valid),
    .chq_tag    (chq_tag),
    .chq_len    (chq_len),
    .flit_sent  (flit_sent),
    .chr_valid  (chr_valid),
    .chr_tag    (chr_tag),
    .chr_ok     (chr_ok),
    .resv_count (resv_count)
  );
endmodule

// File: rtl/gc_reserve_unit_chk.sv
module gc_reserve_unit_chk #(
  parameter int LEN_W = 6,
  parameter int TAG_W = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] thresh,
  input logic             chq_valid,
  input logic [TAG_W-1:0] chq_tag,
  input logic [LEN_W-1:0] chq_len,
  input logic             chr_valid,
  input logic [TAG_W-1:0] chr_tag,
  input logic             chr_ok,
  input logic             flit_sent,
  input logic [CNT_W-1:0] resv_count,
  input logic             req_valid,
  input logic             dec_valid
);
  p_grant_rule_r1: assert property (@(posedge clk) disable iff (rst)
    chq_valid |=> chr_ok == ((CNT_W+1)'($past(resv_count)) + (CNT_W+1)'($past(chq_len))
                             <= (CNT_W+1)'($past(thresh))));

  p_release_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!chq_valid && flit_sent && resv_count != '0) |=> resv_count == $past(resv_count) - 1'b1);

  p_floor_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!chq_valid && resv_count == '0) |=> resv_count == '0);

  p_refuse_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (chq_valid && !flit_sent) |=> (!chr_ok -> resv_count == $past(resv_count)));

  p_reply_next_r6: assert property (@(posedge clk) disable iff (rst)
    chq_valid |=> (chr_valid && chr_tag == $past(chq_tag)));

  p_no_stray_reply_r6: assert property (@(posedge clk) disable iff (rst)
    !chq_valid |=> !chr_valid);

  p_decision_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  p_single_request_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
endmodule

bind gc_reserve_unit gc_reserve_unit_chk #(
  .LEN_W(LEN_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .thresh     (thresh),
  .chq_valid  (chq_valid),
  .chq_tag    (chq_tag),
  .chq_len    (chq_len),
  .chr_valid  (chr_valid),
  .chr_tag    (chr_tag),
  .chr_ok     (chr_ok),
  .flit_sent  (flit_sent),
  .resv_count (resv_count),
  .req_valid  (req_valid),
  .dec_valid  (dec_valid)
);

// File: tb/gc_reserve_unit_test.sv
`timescale 1ns/1ps
module gc_reserve_unit_test;
  localparam int ID_W = 8, LEN_W = 6, TAG_W = 4, CNT_W = 8, DEPTH = 4, TIMEOUT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [CNT_W-1:0] thresh = 8'd20;
  logic pkt_valid = 1'b0;
  logic [ID_W-1:0] pkt_id = '0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic pkt_ready, req_valid, dec_valid, dec_minimal, chr_valid, chr_ok;
  logic [TAG_W-1:0] req_tag, chr_tag;
  logic [LEN_W-1:0] req_len, dec_len;
  logic [ID_W-1:0] dec_id;
  logic [CNT_W-1:0] resv_count;
  logic flit_sent = 1'b0;

  // bench-side transport between the two halves
  logic direct_mode = 1'b0, drop_mode = 1'b0;
  logic drv_valid = 1'b0; logic [TAG_W-1:0] drv_tag = '0; logic [LEN_W-1:0] drv_len = '0;
  logic inj_valid = 1'b0; logic [TAG_W-1:0] inj_tag = '0; logic inj_ok = 1'b0;
  logic chq_valid, rsp_in_valid, rsp_in_ok;
  logic [TAG_W-1:0] chq_tag, rsp_in_tag;
  logic [LEN_W-1:0] chq_len;

  always_comb begin
    chq_valid    = direct_mode ? drv_valid : (req_valid && !drop_mode);
    chq_tag      = direct_mode ? drv_tag : req_tag;
    chq_len      = direct_mode ? drv_len : req_len;
    rsp_in_valid = inj_valid || (!direct_mode && !drop_mode && chr_valid);
    rsp_in_tag   = inj_valid ? inj_tag : chr_tag;
    rsp_in_ok    = inj_valid ? inj_ok : chr_ok;
  end

  gc_reserve_unit uut (
    .clk(clk), .rst(rst), .thresh(thresh),
    .pkt_valid(pkt_valid), .pkt_id(pkt_id), .pkt_len(pkt_len), .pkt_ready(pkt_ready),
    .req_valid(req_valid), .req_tag(req_tag), .req_len(req_len),
    .rsp_in_valid(rsp_in_valid), .rsp_in_tag(rsp_in_tag), .rsp_in_ok(rsp_in_ok),
    .dec_valid(dec_valid), .dec_id(dec_id), .dec_len(dec_len), .dec_minimal(dec_minimal),
    .chq_valid(chq_valid), .chq_tag(chq_tag), .chq_len(chq_len),
    .chr_valid(chr_valid), .chr_tag(chr_tag), .chr_ok(chr_ok),
    .flit_sent(flit_sent), .resv_count(resv_count)
  );

  int errors = 0, checks = 0, cycle = 0;
  int req_pulses = 0, pkts_sent = 0, last_req_cycle = 0, last_dec_cycle = 0;
  logic [ID_W+LEN_W:0] exp_q[$];
  logic [LEN_W-1:0] req_len_q[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cycle <= cycle + 1;

  // monitor: request flits and decisions, sampled away from the edge
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      req_pulses++;
      last_req_cycle = cycle;
      if (req_len_q.size() == 0) chk("R7 unexpected request flit", 1, 0);
      else chk("R7 request length", int'(req_len), int'(req_len_q.pop_front()));
    end
    if (!rst && dec_valid) begin
      last_dec_cycle = cycle;
      if (exp_q.size() == 0) chk("R7 unexpected decision", 1, 0);
      else begin
        logic [ID_W+LEN_W:0] e;
        e = exp_q.pop_front();
        chk("R7 decision id", int'(dec_id), int'(e[ID_W+LEN_W:LEN_W+1]));
        chk("R7 decision length", int'(dec_len), int'(e[LEN_W:1]));
        chk("R8 route choice", int'(dec_minimal), int'(e[0]));
      end
    end
  end

  task automatic send_pkt(input int id, input int len, input bit minimal);
    @(negedge clk);
    while (!pkt_ready) @(negedge clk);
    pkt_valid = 1'b1; pkt_id = ID_W'(id); pkt_len = LEN_W'(len);
    exp_q.push_back({ID_W'(id), LEN_W'(len), minimal});
    req_len_q.push_back(LEN_W'(len));
    pkts_sent++;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int acc;
    logic [TAG_W-1:0] tg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset total", int'(resv_count), 0);
    chk("R11 reset req_valid", int'(req_valid), 0);
    chk("R11 reset dec_valid", int'(dec_valid), 0);
    chk("R11 reset chr_valid", int'(chr_valid), 0);
    chk("R11 reset pkt_ready", int'(pkt_ready), 1);

    // loopback grants and refusals
    send_pkt(1, 8, 1'b1);  wait_idle();
    chk("R2 total after grant of 8", int'(resv_count), 8);
    send_pkt(2, 12, 1'b1); wait_idle();
    chk("R1 grant at exactly the ceiling", int'(resv_count), 20);
    send_pkt(3, 1, 1'b0);  wait_idle();
    chk("R5 refused request keeps total", int'(resv_count), 20);

    // release five flits
    @(negedge clk); flit_sent = 1'b1;
    repeat (5) @(negedge clk);
    flit_sent = 1'b0;
    chk("R3 release by one per flit", int'(resv_count), 15);

    // direct channel tests
    direct_mode = 1'b1;
    drv_valid = 1'b1; drv_len = 6'd5; drv_tag = 4'd7; flit_sent = 1'b1;
    @(negedge clk);
    drv_valid = 1'b0; flit_sent = 1'b0;
    chk("R6 reply valid next cycle", int'(chr_valid), 1);
    chk("R6 reply tag", int'(chr_tag), 7);
    chk("R4 grant with concurrent release ok", int'(chr_ok), 1);
    chk("R4 total after grant plus release", int'(resv_count), 19);
    drv_valid = 1'b1; drv_len = 6'd2; drv_tag = 4'd9;
    @(negedge clk);
    drv_valid = 1'b0;
    chk("R1 refuse one over ceiling", int'(chr_ok), 0);
    chk("R5 total after direct refusal", int'(resv_count), 19);
    drv_valid = 1'b1; drv_len = 6'd1; drv_tag = 4'd3;
    @(negedge clk);
    drv_valid = 1'b0;
    chk("R1 grant filling ceiling", int'(chr_ok), 1);
    chk("R2 total at ceiling", int'(resv_count), 20);
    @(negedge clk);
    chk("R6 single reply per request", int'(chr_valid), 0);
    flit_sent = 1'b1;
    repeat (25) @(negedge clk);
    flit_sent = 1'b0;
    chk("R3 total saturates at zero", int'(resv_count), 0);
    direct_mode = 1'b0;

    // timeout
    drop_mode = 1'b1;
    send_pkt(30, 4, 1'b0); wait_idle();
    chk("R10 timeout latency", last_dec_cycle - last_req_cycle, TIMEOUT);

    // stale reply ignored
    send_pkt(40, 3, 1'b1);
    for (int i = 0; i < 20 && !req_valid; i++) @(negedge clk);
    tg = req_tag;
    @(negedge clk);
    inj_valid = 1'b1; inj_tag = tg + 1'b1; inj_ok = 1'b0;
    @(negedge clk);
    inj_valid = 1'b0;
    @(negedge clk);
    chk("R9 stale reply produced no decision", exp_q.size(), 1);
    inj_valid = 1'b1; inj_tag = tg; inj_ok = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0;
    wait_idle();

    // buffer fill with back-to-back packets, all time out, order kept
    acc = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pkt_ready) begin
        pkt_valid = 1'b1; pkt_id = ID_W'(50 + i); pkt_len = LEN_W'(i + 1);
        exp_q.push_back({ID_W'(50 + i), LEN_W'(i + 1), 1'b0});
        req_len_q.push_back(LEN_W'(i + 1));
        pkts_sent++;
        acc++;
      end else pkt_valid = 1'b0;
    end
    @(negedge clk); pkt_valid = 1'b0;
    chk("R11 packets accepted before full", acc, DEPTH + 1);
    wait_idle();
    drop_mode = 1'b0;
    chk("R7 all decisions delivered", exp_q.size(), 0);
    chk("R12 one request per packet", req_pulses, pkts_sent);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule